// File: doc/BRIEF.md
# Two-Point Offset and Span Corrector

This block turns a raw unsigned converter reading into a corrected value. It removes offset error and span error in one step, using three stored calibration constants. The constants are the ideal full-scale value, the measured full-scale response and the measured zero response. Software or a boot sequence writes them through a small register-load port before samples start to arrive.

Each sample arrives with a valid strobe. The block subtracts the stored zero from the sample and clamps the difference at zero. It multiplies that difference by the ideal full-scale value. It then divides the 32-bit product by the measured span (measured full scale minus zero), using a 16-step restoring divider. So the arithmetic is two unsigned subtractions, one multiply and one divide.

The corrected value comes back with a one-cycle valid pulse. A busy flag tells the source when a new sample can be taken. A quotient that does not fit in 16 bits saturates. A span that is zero or negative gives full scale and sets an error flag.

Top module: `cal_corrector`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `res_valid`, `res_err` and `res_data` are all zero.
- R2: A write with `cfg_we` high loads `cfg_data` into one constant selected by `cfg_sel`: 0 selects the ideal full scale, 1 the measured full scale and 2 the measured zero. A write with selector 3 changes none of them.
- R3: A sample is taken on a rising edge where `smp_valid` is high and `busy` is low. A strobe seen while `busy` is high is ignored and produces no result.
- R4: The result is floor(ideal × (sample − zero) / (full − zero)). `busy` is high from the edge that takes the sample until the 16th edge after it. On that 16th edge `busy` falls and `res_valid` rises.
- R5: A sample at or below the stored zero gives a difference of zero, so the result is 0 (provided the span is valid).
- R6: When the true quotient exceeds 0xFFFF, the result is 0xFFFF and `res_err` stays low.
- R7: When the measured full scale is not greater than the zero, the result is 0xFFFF and `res_err` is high.
- R8: `res_valid` is high for exactly one cycle per result. `res_data` and `res_err` hold their values until the next result.
- R9: A sample presented in the cycle where `res_valid` is high is taken, so results can follow each other every 17 cycles.
- R10: Constant writes made in the cycle that takes a sample, or while that sample is busy, do not change its result. They take effect for the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Constant write strobe |
| cfg_sel | input | 2 | Constant selector (0 ideal, 1 measured full, 2 zero, 3 none) |
| cfg_data | input | 16 | Constant value to write |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Raw sample |
| busy | output | 1 | Division in progress; samples are not taken |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_data | output | 16 | Corrected result |
| res_err | output | 1 | Span was zero or negative for this result |

## Verification
The bench builds the block with its default 16-bit data width. At this width the full 0xFFFF constants drive the product close to the top of its 32-bit range. This puts the exact-0xFFFF quotient, quotient saturation and zero or negative spans all within reach using a handful of chosen constants. A pseudo-random stream then covers ordinary quotients. A held strobe exercises the ignored-while-busy case and back-to-back acceptance. Constant writes made in the middle of a division show that the in-flight result is isolated from later writes.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [1:0] {
    CFG_IDEAL = 2'd0,
    CFG_MEAS  = 2'd1,
    CFG_ZERO  = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;

endpackage

// File: rtl/cal_store.sv
module cal_store #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] ideal_o,
  output logic [DW-1:0] meas_o,
  output logic [DW-1:0] zero_o
);
  import cal_pkg::*;

  logic [DW-1:0] ideal_q, meas_q, zero_q;
  logic          ideal_en, meas_en, zero_en;

  always_comb begin
    ideal_en = wr_en && (cfg_sel_e'(wr_sel) == CFG_IDEAL);
    meas_en  = wr_en && (cfg_sel_e'(wr_sel) == CFG_MEAS);
    zero_en  = wr_en && (cfg_sel_e'(wr_sel) == CFG_ZERO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ideal_q <= '0;
      meas_q  <= '0;
      zero_q  <= '0;
    end else begin
      if (ideal_en) ideal_q <= wr_data;
      if (meas_en)  meas_q  <= wr_data;
      if (zero_en)  zero_q  <= wr_data;
    end
  end

  assign ideal_o = ideal_q;
  assign meas_o  = meas_q;
  assign zero_o  = zero_q;

  // R2: the spare selector leaves every constant untouched
  a_r2_spare_sel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> ($stable(ideal_o) && $stable(meas_o) && $stable(zero_o)));

  // R2: with no write strobe the constants do not move
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ideal_o) && $stable(meas_o) && $stable(zero_o)));

endmodule

// File: rtl/cal_prep.sv
module cal_prep #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   sample_i,
  input  logic [DW-1:0]   ideal_i,
  input  logic [DW-1:0]   meas_i,
  input  logic [DW-1:0]   zero_i,
  output logic [2*DW-1:0] prod_o,
  output logic [DW-1:0]   den_o,
  output logic            err_o,
  output logic            sat_o
);
  localparam int PW = 2 * DW;

  logic [DW-1:0] diff;
  logic [PW-1:0] prod;

  always_comb begin
    // first subtraction: sample minus zero, clamped at zero (R5)
    diff   = (sample_i > zero_i) ? (sample_i - zero_i) : '0;
    // second subtraction: measured span
    den_o  = meas_i - zero_i;
    err_o  = (meas_i <= zero_i);
    prod   = {{DW{1'b0}}, ideal_i} * {{DW{1'b0}}, diff};
    prod_o = prod;
    // quotient fits in DW bits only if the high half is below the divisor (R6)
    sat_o  = !err_o && (prod[PW-1:DW] >= den_o);
  end

endmodule

// File: rtl/cal_divider.sv
module cal_divider #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [2*DW-1:0] prod_i,
  input  logic [DW-1:0]   den_i,
  input  logic            err_i,
  input  logic            sat_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [DW-1:0]   quot_o,
  output logic            err_o
);
  import cal_pkg::*;

  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  div_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rem_q, rem_d;
  logic [DW-1:0] lo_q, lo_d;
  logic [DW-1:0] den_q, den_d;
  logic          ferr_q, ferr_d;
  logic          fsat_q, fsat_d;
  logic          done_q, done_d;
  logic [DW-1:0] quot_q, quot_d;
  logic          rerr_q, rerr_d;

  logic [DW:0]   shifted;
  logic          fits;
  logic [DW-1:0] step_rem;
  logic [DW-1:0] step_lo;

  // one restoring step: shift in the next dividend bit, subtract if it fits
  always_comb begin
    shifted  = {rem_q, lo_q[DW-1]};
    fits     = (shifted >= {1'b0, den_q});
    step_rem = fits ? DW'(shifted - {1'b0, den_q}) : shifted[DW-1:0];
    step_lo  = {lo_q[DW-2:0], fits};
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    lo_d    = lo_q;
    den_d   = den_q;
    ferr_d  = ferr_q;
    fsat_d  = fsat_q;
    done_d  = 1'b0;
    quot_d  = quot_q;
    rerr_d  = rerr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
          rem_d   = (err_i || sat_i) ? '0 : prod_i[2*DW-1:DW];
          lo_d    = prod_i[DW-1:0];
          den_d   = den_i;
          ferr_d  = err_i;
          fsat_d  = sat_i;
        end
      end
      ST_RUN: begin
        rem_d = step_rem;
        lo_d  = step_lo;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          quot_d  = (ferr_q || fsat_q) ? '1 : step_lo;
          rerr_d  = ferr_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rem_q   <= '0;
      lo_q    <= '0;
      den_q   <= '0;
      ferr_q  <= 1'b0;
      fsat_q  <= 1'b0;
      done_q  <= 1'b0;
      quot_q  <= '0;
      rerr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rem_q   <= rem_d;
      lo_q    <= lo_d;
      den_q   <= den_d;
      ferr_q  <= ferr_d;
      fsat_q  <= fsat_d;
      done_q  <= done_d;
      quot_q  <= quot_d;
      rerr_q  <= rerr_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
  assign quot_o = quot_q;
  assign err_o  = rerr_q;

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: result registers hold for the whole run
  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(quot_o) && $stable(err_o)));

  // R4: partial remainder stays below the divisor during a valid division
  a_r4_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !ferr_q) |-> (rem_q < den_q));

  // R3: a run only begins from a start request
  a_r3_run_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R7: an invalid span always reports full scale
  a_r7_err_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (quot_o == '1));

endmodule

// File: rtl/cal_corrector.sv
module cal_corrector #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_data,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  output logic          busy,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic          res_err
);
  localparam int PW = 2 * DW;

  logic [DW-1:0] ideal, meas, zero;
  logic [PW-1:0] prod;
  logic [DW-1:0] den;
  logic          span_err, sat;
  logic          start;
  logic          busy_i;

  assign start = smp_valid && !busy_i;

  cal_store #(.DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_data),
    .ideal_o (ideal),
    .meas_o  (meas),
    .zero_o  (zero)
  );

  cal_prep #(.DW(DW)) u_prep (
    .sample_i (smp_data),
    .ideal_i  (ideal),
    .meas_i   (meas),
    .zero_i   (zero),
    .prod_o   (prod),
    .den_o    (den),
    .err_o    (span_err),
    .sat_o    (sat)
  );

  cal_divider #(.DW(DW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .prod_i  (prod),
    .den_i   (den),
    .err_i   (span_err),
    .sat_i   (sat),
    .busy_o  (busy_i),
    .done_o  (res_valid),
    .quot_o  (res_data),
    .err_o   (res_err)
  );

  assign busy = busy_i;

  // R9: the result cycle is never busy, so a new sample can enter there
  a_r9_valid_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy);

  // R4: the run ends exactly where the result appears
  a_r4_busy_fall_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> res_valid);

endmodule

// File: tb/test_cal_corrector.sv
`timescale 1ns/1ps
module test_cal_corrector;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [DW-1:0] cfg_data = '0;
  logic          smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          busy, res_valid, res_err;
  logic [DW-1:0] res_data;

  always #2.5 clk = ~clk;

  cal_corrector #(.DW(DW)) i_cal_corrector (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .smp_valid(smp_valid), .smp_data(smp_data), .busy(busy), .res_valid(res_valid),
    .res_data(res_data), .res_err(res_err)
  );

  int n_checks = 0;
  int n_errs   = 0;

  // behavioural reference state
  longint m_ideal, m_meas, m_zero;
  bit     m_busy, m_valid, m_err, m_perr;
  int     m_cnt;
  longint m_data, m_pend;
  string  m_tag  = "R8";
  string  m_ptag = "R4";

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic expect_of(input longint s, output longint q, output bit e, output string tag);
    longint diff, p;
    diff = (s > m_zero) ? s - m_zero : 0;
    if (m_meas <= m_zero) begin
      q = 65535; e = 1'b1; tag = "R7";
    end else begin
      p = (m_ideal * diff) / (m_meas - m_zero);
      e = 1'b0;
      if (p > 65535) begin q = 65535; tag = "R6"; end
      else begin q = p; tag = (diff == 0) ? "R5" : "R4"; end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ideal = 0; m_meas = 0; m_zero = 0;
      m_busy = 0; m_valid = 0; m_err = 0; m_cnt = 0; m_data = 0;
    end else begin
      bit acc;
      acc = smp_valid && !m_busy;
      m_valid = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 16) begin
          m_busy = 0; m_valid = 1; m_data = m_pend; m_err = m_perr; m_tag = m_ptag;
        end
      end
      if (acc) begin
        // constants seen at the accepting edge are the pre-write values (R10)
        expect_of(longint'(smp_data), m_pend, m_perr, m_ptag);
        m_busy = 1; m_cnt = 0;
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_ideal = cfg_data;
          2'd1: m_meas  = cfg_data;
          2'd2: m_zero  = cfg_data;
          default: ; // R2: spare selector ignored
        endcase
      end
    end
    #2;
    check(busy == m_busy, "R4", busy, m_busy);
    check(res_valid == m_valid, "R8", res_valid, m_valid);
    check(res_data == DW'(m_data), m_valid ? m_tag : "R8", res_data, m_data);
    check(res_err == m_err, m_valid ? m_tag : "R8", res_err, m_err);
  end

  task automatic write_cfg(input logic [1:0] sel, input logic [DW-1:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_all(input logic [DW-1:0] xi, input logic [DW-1:0] xm, input logic [DW-1:0] xz);
    write_cfg(2'd0, xi);
    write_cfg(2'd1, xm);
    write_cfg(2'd2, xz);
  endtask

  task automatic run_sample(input logic [DW-1:0] s);
    @(negedge clk);
    while (busy) @(negedge clk);
    smp_valid = 1'b1; smp_data = s;
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (17) @(negedge clk);
  endtask

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R1: outputs at rest during reset
    check(busy == 1'b0 && res_valid == 1'b0, "R1", {busy, res_valid}, 0);
    check(res_data == '0 && res_err == 1'b0, "R1", {res_err, res_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && res_valid == 1'b0 && res_data == '0, "R1", res_data, 0);

    // R4: ordinary correction
    set_all(16'd1000, 16'd3000, 16'd1000);
    run_sample(16'd2000);
    run_sample(16'd3000);
    // R5: at and below the zero
    run_sample(16'd500);
    run_sample(16'd1000);
    // exact full-scale quotient without saturation
    set_all(16'hFFFF, 16'hFFFF, 16'd0);
    run_sample(16'hFFFF);
    // R6: quotient overflow
    set_all(16'hFFFF, 16'd1001, 16'd1000);
    run_sample(16'd5000);
    run_sample(16'd1001);
    // R7: zero span and negative span
    set_all(16'd400, 16'd700, 16'd700);
    run_sample(16'd900);
    write_cfg(2'd1, 16'd200);
    run_sample(16'd900);
    // R2: selector 3 leaves constants unchanged
    set_all(16'd2048, 16'd5000, 16'd100);
    write_cfg(2'd3, 16'd7);
    run_sample(16'd2550);
    // R3 and R9: strobe held high through busy and result cycles
    @(negedge clk);
    smp_valid = 1'b1;
    for (int k = 0; k < 60; k++) begin
      smp_data = 16'(200 + 37 * k);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    repeat (18) @(negedge clk);
    // R10: writes during the accepting cycle and while busy
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 16'd3000;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_data = 16'd9;
    @(negedge clk);
    smp_valid = 1'b0; cfg_sel = 2'd2; cfg_data = 16'd2900;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (17) @(negedge clk);
    run_sample(16'd3000);
    // pseudo-random stream
    for (int k = 0; k < 80; k++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      if (k % 8 == 0) set_all(lfsr[15:0], lfsr[31:16] | 16'h8000, {4'h0, lfsr[27:16]});
      run_sample(lfsr[23:8]);
    end
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_errs++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule